// File: doc/BRIEF.md
# Six-Lane Word Concentrator

This block gathers six slow 32-bit word streams and turns them into one fast 32-bit stream for a serial transmitter that runs an 8b/10b line code. Each lane is written in a shared 40 MHz input domain into its own small dual-clock FIFO. A 240 MHz stage, running at exactly six times the input clock, visits the lane FIFOs in a fixed cycle 0,1,2,3,4,5,0,... and moves one word per visit into a bridging dual-clock FIFO. A 250 MHz output stage empties that FIFO. It pads every cycle in which the FIFO is empty with an all-comma idle word, so that the line always carries a symbol.

Lane words arrive with their two 16-bit halves in the wrong order, because the receiver aligns on even bytes. The block swaps the halves before it stores a word. The output carries a per-byte control flag for the encoder and a valid bit. Neither edge has a ready signal. The lanes cannot be stalled: a write to a full lane FIFO is dropped and latched in a sticky per-lane flag. The output cannot be stalled either: a word, idle or data, leaves on every output clock. Each of the three domains has its own synchronous active-high reset.

Top module: `lcc_concentrator`

## Requirements
- R1: Words from one lane leave the block in the order in which they were written. No word is lost or duplicated while the lane FIFO has room.
- R2: For each input word `w`, the data word on the output is `{w[15:0], w[31:16]}`.
- R3: The 240 MHz stage visits lanes 0 to 5 cyclically, one lane per cycle. When every lane has words waiting, consecutive output data words come from lanes `n` and `(n+1) mod 6`.
- R4: A visit to an empty lane moves nothing, and the rotation still advances. With any subset of lanes active, every word of every active lane comes out, and the order follows the active lanes cyclically.
- R5: In every output cycle after the bridging FIFO was empty, `out_valid` is 0, `out_data` is 32'hBCBCBCBC and `out_ctrl` is 4'b1111.
- R6: Each data word leaves with `out_valid` = 1 and `out_ctrl` = 4'b0000.
- R7: While and after the resets, the output shows the idle word with `out_valid` = 0, and `lane_ovf` is all zero.
- R8: A lane FIFO holds 16 words. A write to a full lane FIFO is dropped, the stored words stay intact, and bit `i` of `lane_ovf` (lane `i`) is set. The bit stays set until `in_rst`.
- R9: While only `mid_rst` is held, the lanes keep accepting words and nothing is drained. After its release, the held words come out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | 40 MHz lane write clock |
| in_rst | input | 1 | Synchronous active-high reset, input domain |
| in_valid | input | 6 | Write strobe, one per lane |
| in_data | input | 192 | Lane words, lane `i` at bits `[32i+31:32i]` |
| lane_ovf | output | 6 | Sticky drop flag per lane |
| mid_clk | input | 1 | 240 MHz concentration clock |
| mid_rst | input | 1 | Synchronous active-high reset, concentration domain |
| out_clk | input | 1 | 250 MHz output clock |
| out_rst | input | 1 | Synchronous active-high reset, output domain |
| out_data | output | 32 | Output word, data or idle |
| out_ctrl | output | 4 | Per-byte control-character flag |
| out_valid | output | 1 | 1 for a data word, 0 for idle |

## Verification
A lane FIFO never fills in normal running, because the rotation removes one word per lane in every input period, exactly as fast as words can arrive. The drop path is therefore out of reach by traffic alone. The bench holds only the concentration domain in reset, writes seventeen words into one lane, and then releases the drain to confirm the first sixteen. The rotation order is checked across every non-empty subset of the six lanes, with short simultaneous bursts, so that empty slots occur in every pattern.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam logic [WORD_W-1:0] IDLE_WORD = 32'hBCBCBCBC;
  localparam logic [BYTES-1:0]  IDLE_K    = 4'b1111;

  // exchange the two 16-bit halves of a received word
  function automatic logic [WORD_W-1:0] swap_halves(input logic [WORD_W-1:0] w);
    return {w[WORD_W/2-1:0], w[WORD_W-1:WORD_W/2]};
  endfunction
endpackage

// File: rtl/lcc_gray_sync.sv
module lcc_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lcc_cdc_fifo.sv
module lcc_cdc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         full,
  output logic         ovf,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic          wr_ok;

  assign wr_ok   = wr_en && !full;
  assign wbin_nx = wbin + PW'(1);
  assign rbin_nx = rbin + PW'(1);

  // write side
  assign full = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_ok) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
  end

  lcc_gray_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w));
  lcc_gray_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r));

  // read side
  assign empty = (rgray == wgray_r);
  assign rdata = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_en && !empty) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1); // R1
  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1); // R1
  AST_FULL_WRITE_DROPPED: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && full) |=> $stable(wbin)); // R8
  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (wrst)
    ovf |=> ovf); // R8
  AST_NO_READ_EMPTY: assert property (@(posedge rclk) disable iff (rrst)
    rd_en |-> !empty); // R4
endmodule

// File: rtl/lcc_rr_drain.sv
module lcc_rr_drain #(
  parameter int NCH = 6,
  parameter int W   = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_empty,
  input  logic [W-1:0]   ch_data [NCH],
  output logic [NCH-1:0] ch_rd,
  input  logic           br_full,
  output logic           br_wr,
  output logic [W-1:0]   br_data
);
  localparam int SW = $clog2(NCH);

  logic [SW-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= (slot == SW'(NCH-1)) ? '0 : slot + SW'(1);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_rd
    assign ch_rd[g] = (slot == SW'(g)) && !ch_empty[g] && !br_full;
  end

  assign br_wr = |ch_rd;

  always_comb begin
    br_data = '0;
    for (int i = 0; i < NCH; i++)
      if (slot == SW'(i)) br_data = ch_data[i];
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot == SW'(NCH-1)) |=> (slot == '0)); // R3
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot != SW'(NCH-1)) |=> (slot == $past(slot) + SW'(1))); // R3
endmodule

// File: rtl/lcc_idle_filler.sv
module lcc_idle_filler
  import lcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              empty,
  input  logic [WORD_W-1:0] rdata,
  output logic              rd_en,
  output logic [WORD_W-1:0] out_data,
  output logic [BYTES-1:0]  out_ctrl,
  output logic              out_valid
);
  assign rd_en = !empty;

  always_ff @(posedge clk) begin
    if (rst || empty) begin
      out_data  <= IDLE_WORD;
      out_ctrl  <= IDLE_K;
      out_valid <= 1'b0;
    end else begin
      out_data  <= rdata;
      out_ctrl  <= '0;
      out_valid <= 1'b1;
    end
  end

  AST_IDLE_AFTER_EMPTY: assert property (@(posedge clk) disable iff (rst)
    empty |=> (!out_valid && out_data == IDLE_WORD)); // R5
endmodule

// File: rtl/lcc_concentrator.sv
module lcc_concentrator
  import lcc_pkg::*;
#(
  parameter int NCH      = 6,
  parameter int LANE_DEP = 16,
  parameter int BR_DEP   = 32
) (
  input  logic                  in_clk,
  input  logic                  in_rst,
  input  logic [NCH-1:0]        in_valid,
  input  logic [NCH*WORD_W-1:0] in_data,
  output logic [NCH-1:0]        lane_ovf,
  input  logic                  mid_clk,
  input  logic                  mid_rst,
  input  logic                  out_clk,
  input  logic                  out_rst,
  output logic [WORD_W-1:0]     out_data,
  output logic [BYTES-1:0]      out_ctrl,
  output logic                  out_valid
);
  logic [NCH-1:0]    ch_empty, ch_rd, ch_full;
  logic [WORD_W-1:0] ch_data [NCH];
  logic              br_full, br_wr, br_ovf, br_empty, br_rd;
  logic [WORD_W-1:0] br_wdata, br_rdata;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    lcc_cdc_fifo #(.W(WORD_W), .DEPTH(LANE_DEP)) u_lane (
      .wclk (in_clk),
      .wrst (in_rst),
      .wr_en(in_valid[g]),
      .wdata(swap_halves(in_data[g*WORD_W +: WORD_W])),
      .full (ch_full[g]),
      .ovf  (lane_ovf[g]),
      .rclk (mid_clk),
      .rrst (mid_rst),
      .rd_en(ch_rd[g]),
      .rdata(ch_data[g]),
      .empty(ch_empty[g])
    );
  end

  lcc_rr_drain #(.NCH(NCH), .W(WORD_W)) u_drain (
    .clk     (mid_clk),
    .rst     (mid_rst),
    .ch_empty(ch_empty),
    .ch_data (ch_data),
    .ch_rd   (ch_rd),
    .br_full (br_full),
    .br_wr   (br_wr),
    .br_data (br_wdata)
  );

  lcc_cdc_fifo #(.W(WORD_W), .DEPTH(BR_DEP)) u_bridge (
    .wclk (mid_clk),
    .wrst (mid_rst),
    .wr_en(br_wr),
    .wdata(br_wdata),
    .full (br_full),
    .ovf  (br_ovf),
    .rclk (out_clk),
    .rrst (out_rst),
    .rd_en(br_rd),
    .rdata(br_rdata),
    .empty(br_empty)
  );

  lcc_idle_filler u_out (
    .clk      (out_clk),
    .rst      (out_rst),
    .empty    (br_empty),
    .rdata    (br_rdata),
    .rd_en    (br_rd),
    .out_data (out_data),
    .out_ctrl (out_ctrl),
    .out_valid(out_valid)
  );

  AST_BRIDGE_NO_OVF: assert property (@(posedge mid_clk) disable iff (mid_rst)
    !br_ovf); // R1
  AST_LANE_FULL_FLAGS: assert property (@(posedge in_clk) disable iff (in_rst)
    (|(in_valid & ch_full)) |=> (|lane_ovf)); // R8
endmodule

// File: tb/sim_lcc_concentrator.sv
`timescale 1ns/1ps
module sim_lcc_concentrator;
  localparam realtime T_IN  = 24.0;
  localparam realtime T_MID = 4.0;
  localparam realtime T_OUT = 3.8;
  localparam int      NCH   = 6;

  logic in_clk = 0, mid_clk = 0, out_clk = 0;
  logic in_rst = 1, mid_rst = 1, out_rst = 1;
  logic [NCH-1:0]    in_valid = '0;
  logic [NCH*32-1:0] in_data  = '0;
  logic [NCH-1:0]    lane_ovf;
  logic [31:0]       out_data;
  logic [3:0]        out_ctrl;
  logic              out_valid;

  always #(T_IN/2)  in_clk  = ~in_clk;
  always #(T_MID/2) mid_clk = ~mid_clk;
  always #(T_OUT/2) out_clk = ~out_clk;

  lcc_concentrator u0 (
    .in_clk(in_clk), .in_rst(in_rst), .in_valid(in_valid), .in_data(in_data),
    .lane_ovf(lane_ovf), .mid_clk(mid_clk), .mid_rst(mid_rst),
    .out_clk(out_clk), .out_rst(out_rst), .out_data(out_data),
    .out_ctrl(out_ctrl), .out_valid(out_valid)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // output monitor
  bit mon_on = 0, rot_on = 0, have_prev = 0;
  logic [NCH-1:0] act_mask = '0;
  int prev_ch = 0;
  int next_seq [NCH];
  int cnt [NCH];
  int bad_seq = 0, bad_fmt = 0, bad_rot = 0, bad_idle = 0;

  function automatic int next_active(input int p, input logic [NCH-1:0] m);
    for (int k = 1; k <= NCH; k++)
      if (m[(p + k) % NCH]) return (p + k) % NCH;
    return p;
  endfunction

  task automatic mon_clear();
    for (int c = 0; c < NCH; c++) begin next_seq[c] = 0; cnt[c] = 0; end
    bad_seq = 0; bad_fmt = 0; bad_rot = 0; bad_idle = 0; have_prev = 0;
  endtask

  always @(negedge out_clk) begin
    if (mon_on) begin
      if (out_valid) begin
        int c, s;
        c = int'(out_data[23:16]);
        s = int'(out_data[15:0]);
        if (out_ctrl != 4'b0000 || out_data[31:24] != 8'h5A || c >= NCH) bad_fmt++;
        else begin
          if (s != next_seq[c]) bad_seq++;
          next_seq[c] = s + 1;
          cnt[c]++;
          if (rot_on && have_prev && c != next_active(prev_ch, act_mask)) bad_rot++;
          prev_ch = c;
          have_prev = 1;
        end
      end else if (out_data != 32'hBCBCBCBC || out_ctrl != 4'b1111) bad_idle++;
    end
  end

  // lane word: {seq, 8'h5A, lane}; after the swap it reads {8'h5A, lane, seq}
  task automatic burst(input logic [NCH-1:0] m, input int n);
    for (int s = 0; s < n; s++) begin
      @(posedge in_clk); #1;
      in_valid = m;
      for (int c = 0; c < NCH; c++) in_data[c*32 +: 32] = {16'(s), 8'h5A, 8'(c)};
    end
    @(posedge in_clk); #1;
    in_valid = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge in_clk);
    #1;
  endtask

  task automatic check_burst(input logic [NCH-1:0] m, input int n, input string tag);
    for (int c = 0; c < NCH; c++)
      check(cnt[c] == (m[c] ? n : 0), "R1 R4", $sformatf("%s lane %0d count", tag, c),
            cnt[c], m[c] ? n : 0);
    check(bad_seq == 0, "R1", {tag, " order"}, bad_seq, 0);
    check(bad_fmt == 0, "R2 R6", {tag, " word swap/flag"}, bad_fmt, 0);
    check(bad_rot == 0, "R3 R4", {tag, " rotation"}, bad_rot, 0);
    check(bad_idle == 0, "R5", {tag, " idle fill"}, bad_idle, 0);
  endtask

  task automatic all_reset();
    mon_on = 0;
    @(posedge in_clk); #1;
    in_rst = 1; mid_rst = 1; out_rst = 1;
    settle(4);
  endtask

  initial begin
    // reset state
    settle(4);
    @(negedge out_clk);
    check(out_valid == 0, "R7", "valid in reset", out_valid, 0);
    check(out_data == 32'hBCBCBCBC && out_ctrl == 4'hF, "R7", "idle in reset",
          out_data, 32'hBCBCBCBC);
    check(lane_ovf == 0, "R7", "ovf in reset", lane_ovf, 0);
    in_rst = 0; mid_rst = 0; out_rst = 0;
    settle(6);
    @(negedge out_clk);
    check(out_valid == 0 && out_data == 32'hBCBCBCBC, "R7", "idle after reset",
          out_data, 32'hBCBCBCBC);

    // sustained load on all lanes
    mon_clear(); mon_on = 1; rot_on = 1; act_mask = 6'h3F;
    burst(6'h3F, 40);
    settle(30);
    check_burst(6'h3F, 40, "all lanes R3");
    check(lane_ovf == 0, "R8", "no drop at full rate", lane_ovf, 0);

    // every non-empty lane subset
    for (int m = 1; m < 64; m++) begin
      mon_clear(); act_mask = 6'(m);
      burst(6'(m), 3);
      settle(12);
      check_burst(6'(m), 3, $sformatf("mask %02h", m));
    end

    // drop path: drain held in reset (R9), lane 0 overfilled (R8)
    all_reset();
    @(posedge in_clk); #1;
    in_rst = 0; out_rst = 0;
    settle(4);
    check(lane_ovf == 0, "R8", "ovf cleared by in_rst", lane_ovf, 0);
    mon_clear(); mon_on = 1; rot_on = 0;
    burst(6'b000001, 17);
    settle(4);
    check(lane_ovf == 6'b000001, "R8", "ovf after 17th write", lane_ovf, 1);
    check(cnt[0] == 0, "R9", "nothing drained while mid in reset", cnt[0], 0);
    mid_rst = 0;
    settle(20);
    check(cnt[0] == 16, "R8 R9", "held words drained", cnt[0], 16);
    check(bad_seq == 0 && bad_fmt == 0 && bad_idle == 0, "R8", "held words intact",
          bad_seq + bad_fmt + bad_idle, 0);
    check(lane_ovf == 6'b000001, "R8", "ovf sticky", lane_ovf, 1);

    all_reset();
    check(lane_ovf == 0, "R7", "ovf clear on reset", lane_ovf, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(T_IN * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule